// File: doc/BRIEF.md
# Two-Sub-Phase Address Parity Unit

This block produces and verifies the two address parity lines of a split-transaction processor bus. A request occupies two consecutive cycles. In the first cycle the 33 active-low address lines carry the physical address (address bits 35 down to 3). In the second cycle the same lines carry transaction-type information. Five active-low request-code lines are present in both cycles. The initiator drives one combinational parity pair together with the active-low address strobe and the lines. A receiver compares the parity pair it observed against the one it recomputes, and it records one mismatch vector for each sub-phase.

Each parity line covers one of two groups. The high group is address bits 35..24 (`addr_n[32:21]`). The low group is address bits 23..3 (`addr_n[20:0]`) together with all request lines. A parity line is driven high when an even number of its covered lines are low. In sub-phase 1, parity bit 0 covers the high group and bit 1 covers the low group. In sub-phase 2 the two bits swap groups. The sub-phase is tracked inside the block from the strobe.

The bus has no back-pressure and no valid/ready handshake. The strobe is the only qualifier, and the block accepts every cycle it is given. The error outputs are plain status levels, with no acknowledge.

Top module: `addr_parity_unit`

## Requirements
- R1: While `strb_n` is 0 (sub-phase 1), `par_tx[0]` is 1 exactly when an even number of `addr_n[32:21]` are 0. `par_tx[1]` is 1 exactly when an even number of `{addr_n[20:0], req_n}` are 0.
- R2: In the cycle after a `strb_n`=0 cycle, if `strb_n` is 1 (sub-phase 2), the groups swap. `par_tx[1]` follows the high group and `par_tx[0]` follows the low group, using the same even-low rule.
- R3: With every address and request line high, `par_tx` is 2'b11 in both sub-phases.
- R4: A `strb_n`=0 cycle is always sub-phase 1, even when it falls in the cycle where sub-phase 2 is pending. In that case the pending sub-phase 2 is abandoned.
- R5: One cycle after a sub-phase 1 cycle, `err_sub1[i]` is 1 exactly when `par_rx[i]` differed from the sub-phase 1 value of `par_tx[i]` in that cycle. It holds until the next sub-phase 1 check.
- R6: One cycle after a sub-phase 2 cycle, `err_sub2[i]` is 1 exactly when `par_rx[i]` differed from the sub-phase 2 value of `par_tx[i]`. It holds until the next sub-phase 2 check.
- R7: `err_pulse` is 1 for exactly the one cycle after a checked sub-phase that had any mismatch. Otherwise it is 0.
- R8: In a cycle with `strb_n`=1 and no pending sub-phase 2, no check is made. The next cycle `err_sub1` and `err_sub2` are unchanged and `err_pulse` is 0, whatever `par_rx` holds.
- R9: Synchronous active-high `rst` clears `err_sub1`, `err_sub2` and `err_pulse`, and drops any pending sub-phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_n | input | 1 | Address strobe, active low; marks sub-phase 1 |
| addr_n | input | 33 | Address lines, active low, index 0 = address bit 3 |
| req_n | input | 5 | Request-code lines, active low |
| par_rx | input | 2 | Parity pair observed on the bus |
| par_tx | output | 2 | Parity pair to drive, combinational |
| err_sub1 | output | 2 | Per-bit mismatch of the last sub-phase 1 check |
| err_sub2 | output | 2 | Per-bit mismatch of the last sub-phase 2 check |
| err_pulse | output | 1 | One-cycle flag for a check that had a mismatch |

## Verification
`par_tx` is combinational, so it is due in the same cycle as the lines and strobe that produce it. The bench drives inputs at the falling edge and samples one time unit later, before any rising edge. The error vectors and `err_pulse` pass through a single register. The bench therefore reads them at the falling edge after the rising edge that ends the checked cycle. By then it has already driven the stimulus for the following cycle, which cannot reach those registers until the next rising edge. Idle, restart and reset cases are followed by one more sampled cycle, which confirms that nothing changed.

// File: rtl/apu_pkg.sv
package apu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SUB1 = 2'd1,
    PH_SUB2 = 2'd2
  } apu_phase_e;

  typedef struct packed {
    logic [1:0] sub1;
    logic [1:0] sub2;
    logic       pulse;
  } apu_err_t;
endpackage

// File: rtl/apu_phase_track.sv
module apu_phase_track
  import apu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strb_n,
  output apu_phase_e phase
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= ~strb_n;
  end

  always_comb begin
    if (!strb_n)     phase = PH_SUB1;
    else if (pend_q) phase = PH_SUB2;
    else             phase = PH_IDLE;
  end
endmodule

// File: rtl/apu_group_par.sv
module apu_group_par #(
  parameter int W = 12
) (
  input  logic [W-1:0] lines,
  output logic         par
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_low
    assign chain[g+1] = chain[g] ^ ~lines[g];
  end
  assign par = ~chain[W];
endmodule

// File: rtl/apu_parity_map.sv
module apu_parity_map
  import apu_pkg::*;
(
  input  apu_phase_e phase,
  input  logic       hi_par,
  input  logic       lo_par,
  output logic [1:0] par
);
  always_comb begin
    if (phase == PH_SUB2) par = {hi_par, lo_par};
    else                  par = {lo_par, hi_par};
  end
endmodule

// File: rtl/apu_err_reg.sv
module apu_err_reg
  import apu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  apu_phase_e phase,
  input  logic [1:0] exp_par,
  input  logic [1:0] obs_par,
  output apu_err_t   err
);
  logic [1:0] miss;
  assign miss = exp_par ^ obs_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= '0;
    end else begin
      err.pulse <= 1'b0;
      if (phase == PH_SUB1) begin
        err.sub1  <= miss;
        err.pulse <= |miss;
      end else if (phase == PH_SUB2) begin
        err.sub2  <= miss;
        err.pulse <= |miss;
      end
    end
  end
endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit
  import apu_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int REQ_W  = 5,
  parameter int HI_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_n,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [REQ_W-1:0]  req_n,
  input  logic [1:0]        par_rx,
  output logic [1:0]        par_tx,
  output logic [1:0]        err_sub1,
  output logic [1:0]        err_sub2,
  output logic              err_pulse
);
  localparam int LO_W  = ADDR_W - HI_W;
  localparam int GRP_W = LO_W + REQ_W;

  apu_phase_e phase;
  logic       hi_par, lo_par;
  apu_err_t   err;

  apu_phase_track u_trk (.clk(clk), .rst(rst), .strb_n(strb_n), .phase(phase));

  apu_group_par #(.W(HI_W)) u_hi (.lines(addr_n[ADDR_W-1:LO_W]), .par(hi_par));
  apu_group_par #(.W(GRP_W)) u_lo (.lines({addr_n[LO_W-1:0], req_n}), .par(lo_par));

  apu_parity_map u_map (.phase(phase), .hi_par(hi_par), .lo_par(lo_par), .par(par_tx));

  apu_err_reg u_err (
    .clk(clk), .rst(rst), .phase(phase),
    .exp_par(par_tx), .obs_par(par_rx), .err(err)
  );

  assign err_sub1  = err.sub1;
  assign err_sub2  = err.sub2;
  assign err_pulse = err.pulse;
endmodule

// File: rtl/apu_checker.sv
module apu_checker #(
  parameter int ADDR_W = 33,
  parameter int REQ_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_n,
  input logic [ADDR_W-1:0] addr_n,
  input logic [REQ_W-1:0]  req_n,
  input logic [1:0]        par_rx,
  input logic [1:0]        par_tx,
  input logic [1:0]        err_sub1,
  input logic [1:0]        err_sub2,
  input logic              err_pulse
);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (err_sub1 == 2'b00 && err_sub2 == 2'b00 && !err_pulse));

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_sub1 != 2'b00 || err_sub2 != 2'b00));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_n && $past(strb_n)) |=> ($stable(err_sub1) && $stable(err_sub2) && !err_pulse));

  // R3
  all_high_chk: assert property (@(posedge clk) disable iff (rst)
    (&addr_n && &req_n) |-> par_tx == 2'b11);

  // R5
  sub1_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_n && par_rx == par_tx) |=> err_sub1 == 2'b00);

  // R6
  sub2_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_n && !$past(strb_n) && par_rx == par_tx) |=> err_sub2 == 2'b00);
endmodule

bind addr_parity_unit apu_checker #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .strb_n(strb_n), .addr_n(addr_n), .req_n(req_n),
  .par_rx(par_rx), .par_tx(par_tx), .err_sub1(err_sub1), .err_sub2(err_sub2),
  .err_pulse(err_pulse)
);

// File: tb/sim_addr_parity_unit.sv
module sim_addr_parity_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strb_n = 1'b1;
  logic [32:0] addr_n = '1;
  logic [4:0]  req_n = '1;
  logic [1:0]  par_rx = 2'b11;
  logic [1:0]  par_tx, err_sub1, err_sub2;
  logic        err_pulse;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_parity_unit u0 (
    .clk(clk), .rst(rst), .strb_n(strb_n), .addr_n(addr_n), .req_n(req_n),
    .par_rx(par_rx), .par_tx(par_tx), .err_sub1(err_sub1), .err_sub2(err_sub2),
    .err_pulse(err_pulse)
  );

  function automatic logic even_low_hi(input logic [32:0] a);
    int z = 0;
    for (int i = 21; i <= 32; i++) if (!a[i]) z++;
    return (z % 2) == 0;
  endfunction

  function automatic logic even_low_lo(input logic [32:0] a, input logic [4:0] r);
    int z = 0;
    for (int i = 0; i <= 20; i++) if (!a[i]) z++;
    for (int i = 0; i < 5; i++) if (!r[i]) z++;
    return (z % 2) == 0;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; strb_n = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0; #1;
    chk("R9 reset sub1", {2'b0, err_sub1}, 4'b0);
    chk("R9 reset sub2", {2'b0, err_sub2}, 4'b0);
    chk("R9 reset pulse", {3'b0, err_pulse}, 4'b0);
  endtask

  // full two-sub-phase request with chosen receive errors, then an idle cycle
  task automatic t_txn(input logic [32:0] a1, input logic [4:0] r1, input logic [1:0] f1,
                       input logic [32:0] a2, input logic [4:0] r2, input logic [1:0] f2);
    logic [1:0] e1, e2;
    @(negedge clk); strb_n = 1'b0; addr_n = a1; req_n = r1; #1;
    e1 = {even_low_lo(a1, r1), even_low_hi(a1)};
    chk("R1 sub1 parity", {2'b0, par_tx}, {2'b0, e1});
    par_rx = e1 ^ f1;
    @(negedge clk); strb_n = 1'b1; addr_n = a2; req_n = r2; #1;
    e2 = {even_low_hi(a2), even_low_lo(a2, r2)};
    chk("R2 sub2 parity", {2'b0, par_tx}, {2'b0, e2});
    par_rx = e2 ^ f2;
    chk("R5 err_sub1", {2'b0, err_sub1}, {2'b0, f1});
    chk("R7 pulse after sub1", {3'b0, err_pulse}, {3'b0, |f1});
    @(negedge clk); addr_n = ~a2; par_rx = ~par_tx; #1;
    chk("R6 err_sub2", {2'b0, err_sub2}, {2'b0, f2});
    chk("R7 pulse after sub2", {3'b0, err_pulse}, {3'b0, |f2});
    @(negedge clk); #1;
    chk("R8 idle sub1 hold", {2'b0, err_sub1}, {2'b0, f1});
    chk("R8 idle sub2 hold", {2'b0, err_sub2}, {2'b0, f2});
    chk("R8 idle no pulse", {3'b0, err_pulse}, 4'b0);
  endtask

  task automatic t_all_high();
    @(negedge clk); strb_n = 1'b0; addr_n = '1; req_n = '1; par_rx = 2'b11; #1;
    chk("R3 all high sub1", {2'b0, par_tx}, 4'b0011);
    @(negedge clk); strb_n = 1'b1; #1;
    chk("R3 all high sub2", {2'b0, par_tx}, 4'b0011);
    @(negedge clk); #1;
    chk("R3 clean checks", {err_sub1, err_sub2}, 4'b0);
  endtask

  task automatic t_restart();
    logic [32:0] a = 33'h0_F0F0_1234;
    logic [4:0]  r = 5'b10110;
    logic [1:0]  e1, e1b;
    @(negedge clk); strb_n = 1'b0; addr_n = a; req_n = r; #1;
    e1 = {even_low_lo(a, r), even_low_hi(a)};
    par_rx = e1 ^ 2'b01;
    @(negedge clk); strb_n = 1'b0; addr_n = ~a; req_n = ~r; #1;
    e1b = {even_low_lo(~a, ~r), even_low_hi(~a)};
    chk("R4 restart keeps sub1 map", {2'b0, par_tx}, {2'b0, e1b});
    chk("R4 first sub1 err", {2'b0, err_sub1}, 4'b0001);
    par_rx = e1b ^ 2'b10;
    @(negedge clk); strb_n = 1'b1; #1;
    chk("R4 second sub1 err", {2'b0, err_sub1}, 4'b0010);
    chk("R4 sub2 untouched", {2'b0, err_sub2}, 4'b0);
    par_rx = {even_low_hi(~a), even_low_lo(~a, ~r)};
    @(negedge clk); #1;
    chk("R4 sub2 of restart clean", {2'b0, err_sub2}, 4'b0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); strb_n = 1'b0; addr_n = 33'h1_2345_6789; req_n = 5'b00001; par_rx = ~par_tx;
    @(negedge clk); rst = 1'b1; strb_n = 1'b1; par_rx = ~par_tx;
    @(negedge clk); rst = 1'b0; #1;
    chk("R9 mid reset clears", {err_sub1, err_sub2}, 4'b0);
    chk("R9 mid reset pulse", {3'b0, err_pulse}, 4'b0);
    chk("R9 pending dropped map", {2'b0, par_tx},
        {2'b0, even_low_lo(addr_n, req_n), even_low_hi(addr_n)});
    par_rx = ~par_tx;
    @(negedge clk); #1;
    chk("R9 no sub2 after reset", {err_sub1, err_sub2}, 4'b0);
  endtask

  initial begin
    do_reset();
    t_txn(33'h0_0000_0000, 5'b00000, 2'b00, 33'h1_FFFF_FFFF, 5'b11111, 2'b00);
    t_txn(33'h1_A5A5_3C3C, 5'b01011, 2'b01, 33'h0_5A5A_C3C3, 5'b10100, 2'b10);
    t_txn(33'h0_8000_0001, 5'b11110, 2'b11, 33'h1_0000_0100, 5'b00111, 2'b00);
    for (int k = 0; k < 6; k++)
      t_txn({$urandom, $urandom} & 33'h1_FFFF_FFFF, 5'($urandom), 2'($urandom),
            {$urandom, $urandom} & 33'h1_FFFF_FFFF, 5'($urandom), 2'($urandom));
    t_all_high();
    t_restart();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule